// File: doc/BRIEF.md
# Four-by-Three Priority Bus Crossbar

This block connects four bus masters to three bus slaves. Every master drives a request with a 32-bit address, a 64-bit write word, a read/write flag and a marker for the final beat of its transaction. It gets back a 64-bit read word, a ready strobe and an error flag. The two most significant address bits choose the target slave. The fourth code in those bits maps to no slave: such an access finishes at once and raises the error flag.

Each slave port has its own arbiter. When several masters want the same port, the arbiter picks one from a programmable 2-bit priority per master. The winner keeps the port until the slave accepts its final beat. Masters that lose see ready held low, which stalls them. Paths to different slaves do not interact, so all three slaves can move a beat in the same cycle.

Software sets the priorities through a write strobe that loads one slave's priority word. A new setting is used only when that slave's port is idle. It never takes a port away from a transaction that is already running.

Top module: `prio_xbar`

## Requirements
- R1: A request whose address bits [31:30] are 00, 01 or 10 goes to slave 0, 1 or 2. When the request is granted, `s_sel` for that slave is high in the same cycle, and the slave's address, write word, write flag and last flag equal the granted master's.
- R2: A request whose address bits [31:30] are 11 gets `m_ready`=1 and `m_err`=1 in the same cycle. It selects no slave. `m_err` is never high for a mapped or absent request.
- R3: Masters that target different slaves are all granted and served in the same cycle.
- R4: Among masters requesting an idle slave, the one with the lowest priority value wins. Master m's priority for slave s sits in bits [2m+1:2m] of the word loaded with `cfg_slave`=s.
- R5: When the lowest priority value is shared by several requesters, the lowest-numbered of them wins.
- R6: Once a master is granted a slave, it keeps that slave until the slave accepts a beat from it with `m_last`=1. Any other master requesting that slave sees `m_ready`=0 in the meantime.
- R7: The port is released in the cycle in which the owner's last beat is accepted. In that cycle no other master is served. A new arbitration decides the owner in the following cycle.
- R8: A priority write takes effect one cycle after `cfg_we` is sampled. It affects only arbitration done while the port is idle and never moves a port away from its current owner.
- R9: Read data and ready come only from the slave a master owns. Any master that is not served sees `m_ready`=0 and `m_rdata`=0.
- R10: After reset all priorities are 0, no slave is selected, and no master sees ready or error while it is not requesting.
- R11: While the slave holds `s_ready` low, the owner's `m_ready` is 0 and the owner keeps the port, even when a master with better priority is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req | input | 4 | Per-master request valid |
| m_write | input | 4 | Per-master write flag (1 = write) |
| m_last | input | 4 | Per-master final-beat marker |
| m_addr | input | 128 | Master addresses, master m at [32m+31:32m] |
| m_wdata | input | 256 | Master write words, master m at [64m+63:64m] |
| m_rdata | output | 256 | Read words back to masters |
| m_ready | output | 4 | Beat accepted for master |
| m_err | output | 4 | Unmapped-address completion |
| s_sel | output | 3 | Slave selected (beat valid) |
| s_write | output | 3 | Write flag to slave |
| s_last | output | 3 | Final-beat marker to slave |
| s_addr | output | 96 | Addresses to slaves |
| s_wdata | output | 192 | Write words to slaves |
| s_rdata | input | 192 | Read words from slaves |
| s_ready | input | 3 | Slave accepts the current beat |
| cfg_we | input | 1 | Priority word write strobe |
| cfg_slave | input | 2 | Slave whose priority word is written |
| cfg_prio | input | 8 | Priority word, 2 bits per master |

## Verification
The bench has a lower-priority master start a multi-beat transaction. A better master then asks for the same slave. A design that arbitrates on every beat would hand the port over mid-transaction. A design that releases too early would serve the waiting master in the owner's last cycle. The bench also reprograms priorities while a port is busy, to catch a design that lets the new setting preempt the owner or ignores it after release. It covers a stall while a master waits and equal-priority ties, where a wrong design would pick the higher-numbered master. It checks that unmapped accesses complete with the error flag and never reach a slave.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
// Shared types for the priority crossbar.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package xbar_pkg;
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/xbar_decode.sv
`timescale 1ns/1ps
// Address decoder for one master: takes the top SEL_W address bits as a
// slave index and flags codes at or above N_S as unmapped.
// Assumes the address stays inside one slave for a whole transaction.
module xbar_decode #(
    parameter int AW    = 32,
    parameter int N_S   = 3,
    parameter int SEL_W = 2
) (
    input  logic [AW-1:0]    addr,
    output logic [SEL_W-1:0] tgt,
    output logic             mapped
);
    // Slice the select field and range-check it against the slave count.
    always_comb begin
        tgt    = addr[AW-1 -: SEL_W];
        mapped = (int'(tgt) < N_S);
    end
endmodule

// File: rtl/xbar_prio_cfg.sv
`timescale 1ns/1ps
// Holds one priority word per slave port. A write loads the word of the
// chosen slave on the next edge. Reset clears every priority to 0.
// Assumes cfg_slave values at or above N_S are dropped.
module xbar_prio_cfg #(
    parameter int N_M   = 4,
    parameter int N_S   = 3,
    parameter int PW    = 2,
    parameter int SEL_W = 2,
    localparam int WW   = N_M * PW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_slave,
    input  logic [WW-1:0]      cfg_prio,
    output logic [N_S*WW-1:0]  prio_all
);
    genvar s;
    generate
        for (s = 0; s < N_S; s++) begin : g_word
            logic [WW-1:0] word_q;
            // Load this slave's priority word when it is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (cfg_we && (cfg_slave == SEL_W'(s)))
                    word_q <= cfg_prio;
            end
            assign prio_all[s*WW +: WW] = word_q;
        end
    endgenerate
endmodule

// File: rtl/xbar_arb.sv
`timescale 1ns/1ps
// Arbiter for one slave port. While idle it grants the requester with the
// lowest priority value (lowest index on ties) in the same cycle. It then
// holds that owner until a last beat is accepted and goes idle again.
// Assumes req only contains masters that target this slave.
module xbar_arb
    import xbar_pkg::*;
#(
    parameter int N_M  = 4,
    parameter int PW   = 2,
    localparam int IW  = (N_M > 1) ? $clog2(N_M) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_M-1:0]    req,
    input  logic [N_M*PW-1:0] prio,
    input  logic              sel_last,
    input  logic              slv_ready,
    output logic [IW-1:0]     gnt_idx,
    output logic              gnt_vld
);
    arb_state_e     state_q;
    logic [IW-1:0]  owner_q;
    logic [IW-1:0]  win_idx;
    logic           win_vld;
    logic [PW-1:0]  best;
    logic           release_now;

    // Pick the strictly best priority; the first index found wins ties.
    always_comb begin
        win_idx = '0;
        win_vld = 1'b0;
        best    = '1;
        for (int i = 0; i < N_M; i++) begin
            if (req[i] && (!win_vld || (prio[i*PW +: PW] < best))) begin
                win_vld = 1'b1;
                win_idx = IW'(i);
                best    = prio[i*PW +: PW];
            end
        end
    end

    // Present the held owner, or the fresh winner while idle.
    always_comb begin
        if (state_q == ARB_HELD) begin
            gnt_idx = owner_q;
            gnt_vld = req[owner_q];
        end else begin
            gnt_idx = win_idx;
            gnt_vld = win_vld;
        end
        release_now = gnt_vld && slv_ready && sel_last;
    end

    // Track ownership: release on an accepted last beat, lock on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
        end else if (release_now) begin
            state_q <= ARB_IDLE;
        end else if ((state_q == ARB_IDLE) && win_vld) begin
            state_q <= ARB_HELD;
            owner_q <= win_idx;
        end
    end
endmodule

// File: rtl/xbar_resp.sv
`timescale 1ns/1ps
// Response path for one master. Unmapped requests finish at once with the
// error flag. Mapped ones get ready and read data only from the slave whose
// grant points at this master. Anyone else sees zeros.
// Assumes tgt and mapped come from this master's decoder.
module xbar_resp #(
    parameter int MIDX  = 0,
    parameter int N_S   = 3,
    parameter int DW    = 64,
    parameter int SEL_W = 2,
    parameter int IW    = 2
) (
    input  logic              req,
    input  logic [SEL_W-1:0]  tgt,
    input  logic              mapped,
    input  logic [N_S-1:0]    sel_vld,
    input  logic [N_S*IW-1:0] gnt_idx,
    input  logic [N_S-1:0]    s_ready,
    input  logic [N_S*DW-1:0] s_rdata,
    output logic              ready,
    output logic              err,
    output logic [DW-1:0]     rdata
);
    // Route back the owned slave's reply, or complete an unmapped access.
    always_comb begin
        ready = 1'b0;
        err   = 1'b0;
        rdata = '0;
        if (req) begin
            if (!mapped) begin
                ready = 1'b1;
                err   = 1'b1;
            end else begin
                for (int s = 0; s < N_S; s++) begin
                    if ((tgt == SEL_W'(s)) && sel_vld[s] &&
                        (gnt_idx[s*IW +: IW] == IW'(MIDX))) begin
                        ready = s_ready[s];
                        rdata = s_rdata[s*DW +: DW];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/prio_xbar.sv
`timescale 1ns/1ps
// Top of the crossbar: one decoder and response path per master, one
// arbiter and forward mux per slave, and the priority word registers.
// Assumes a master keeps its address inside one slave for a transaction
// and may drop its request between beats without losing ownership.
module prio_xbar #(
    parameter int N_M   = 4,
    parameter int N_S   = 3,
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int PW    = 2,
    parameter int SEL_W = 2,
    localparam int IW   = (N_M > 1) ? $clog2(N_M) : 1,
    localparam int WW   = N_M * PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_M-1:0]    m_req,
    input  logic [N_M-1:0]    m_write,
    input  logic [N_M-1:0]    m_last,
    input  logic [N_M*AW-1:0] m_addr,
    input  logic [N_M*DW-1:0] m_wdata,
    output logic [N_M*DW-1:0] m_rdata,
    output logic [N_M-1:0]    m_ready,
    output logic [N_M-1:0]    m_err,
    output logic [N_S-1:0]    s_sel,
    output logic [N_S-1:0]    s_write,
    output logic [N_S-1:0]    s_last,
    output logic [N_S*AW-1:0] s_addr,
    output logic [N_S*DW-1:0] s_wdata,
    input  logic [N_S*DW-1:0] s_rdata,
    input  logic [N_S-1:0]    s_ready,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_slave,
    input  logic [WW-1:0]     cfg_prio
);
    logic [N_M*SEL_W-1:0] tgt_all;
    logic [N_M-1:0]       mapped_all;
    logic [N_S*WW-1:0]    prio_all;
    logic [N_S*IW-1:0]    gnt_idx_all;
    logic [N_S-1:0]       gnt_vld_all;

    xbar_prio_cfg #(
        .N_M(N_M), .N_S(N_S), .PW(PW), .SEL_W(SEL_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slave(cfg_slave),
        .cfg_prio(cfg_prio), .prio_all(prio_all)
    );

    genvar m, s;
    generate
        for (m = 0; m < N_M; m++) begin : g_mst
            xbar_decode #(.AW(AW), .N_S(N_S), .SEL_W(SEL_W)) u_dec (
                .addr(m_addr[m*AW +: AW]),
                .tgt(tgt_all[m*SEL_W +: SEL_W]),
                .mapped(mapped_all[m])
            );
            xbar_resp #(
                .MIDX(m), .N_S(N_S), .DW(DW), .SEL_W(SEL_W), .IW(IW)
            ) u_resp (
                .req(m_req[m]), .tgt(tgt_all[m*SEL_W +: SEL_W]),
                .mapped(mapped_all[m]), .sel_vld(gnt_vld_all),
                .gnt_idx(gnt_idx_all), .s_ready(s_ready), .s_rdata(s_rdata),
                .ready(m_ready[m]), .err(m_err[m]),
                .rdata(m_rdata[m*DW +: DW])
            );
        end

        for (s = 0; s < N_S; s++) begin : g_slv
            logic [N_M-1:0] req_here;
            logic [IW-1:0]  gidx;
            logic           gvld;
            logic           glast;

            // Collect the masters that want this slave port.
            always_comb begin
                for (int i = 0; i < N_M; i++)
                    req_here[i] = m_req[i] && mapped_all[i] &&
                                  (tgt_all[i*SEL_W +: SEL_W] == SEL_W'(s));
                glast = m_last[gidx];
            end

            xbar_arb #(.N_M(N_M), .PW(PW)) u_arb (
                .clk(clk), .rst_n(rst_n), .req(req_here),
                .prio(prio_all[s*WW +: WW]), .sel_last(glast),
                .slv_ready(s_ready[s]), .gnt_idx(gidx), .gnt_vld(gvld)
            );

            // Forward the granted master's beat to the slave.
            always_comb begin
                s_sel[s]             = gvld;
                s_write[s]           = gvld && m_write[gidx];
                s_last[s]            = gvld && glast;
                s_addr[s*AW +: AW]   = m_addr[int'(gidx)*AW +: AW];
                s_wdata[s*DW +: DW]  = m_wdata[int'(gidx)*DW +: DW];
            end

            assign gnt_idx_all[s*IW +: IW] = gidx;
            assign gnt_vld_all[s]          = gvld;
        end
    endgenerate
endmodule

// File: rtl/xbar_chk.sv
`timescale 1ns/1ps
// Port-level checker for the crossbar, bound to every instance of it.
// It keeps its own record of which master is part-way through a
// transaction on each slave, rebuilt from accepted beats.
module xbar_chk #(
    parameter int N_M   = 4,
    parameter int N_S   = 3,
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int PW    = 2,
    parameter int SEL_W = 2,
    localparam int IW   = (N_M > 1) ? $clog2(N_M) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_M-1:0]    m_req,
    input logic [N_M-1:0]    m_last,
    input logic [N_M*AW-1:0] m_addr,
    input logic [N_M-1:0]    m_ready,
    input logic [N_M-1:0]    m_err,
    input logic [N_S-1:0]    s_sel,
    input logic [N_S*AW-1:0] s_addr,
    input logic [N_S-1:0]    s_ready
);
    logic [N_S-1:0] lk_vld;
    logic [IW-1:0]  lk_m [N_S];

    // Record a master mid-transaction after it has a non-last beat accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_vld <= '0;
            for (int s = 0; s < N_S; s++) lk_m[s] <= '0;
        end else begin
            for (int s = 0; s < N_S; s++)
                for (int m = 0; m < N_M; m++)
                    if (m_req[m] && m_ready[m] && !m_err[m] &&
                        (m_addr[m*AW+AW-1 -: SEL_W] == SEL_W'(s))) begin
                        lk_vld[s] <= !m_last[m];
                        lk_m[s]   <= IW'(m);
                    end
        end
    end

    genvar m, s;
    generate
        for (m = 0; m < N_M; m++) begin : g_m
            logic [SEL_W-1:0] tg;
            assign tg = m_addr[m*AW+AW-1 -: SEL_W];

            p_unmapped_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (m_req[m] && (int'(tg) >= N_S)) |-> (m_ready[m] && m_err[m]));
            p_err_only_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
                m_err[m] |-> (m_req[m] && (int'(tg) >= N_S)));
            p_ready_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
                m_ready[m] |-> m_req[m]);
            p_stall_passes_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (m_ready[m] && !m_err[m]) |-> s_ready[tg]);

            for (s = 0; s < N_S; s++) begin : g_s
                p_owner_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    (lk_vld[s] && (lk_m[s] != IW'(m)) && m_req[m] &&
                     (tg == SEL_W'(s))) |-> !m_ready[m]);
            end
        end

        for (s = 0; s < N_S; s++) begin : g_sl
            logic [N_M-1:0] served;
            // Masters served by this slave in the current cycle.
            always_comb begin
                for (int i = 0; i < N_M; i++)
                    served[i] = m_ready[i] && !m_err[i] &&
                                (m_addr[i*AW+AW-1 -: SEL_W] == SEL_W'(s));
            end
            p_one_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(served));
            p_route_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
                s_sel[s] |-> (s_addr[s*AW+AW-1 -: SEL_W] == SEL_W'(s)));
        end
    endgenerate
endmodule

bind prio_xbar xbar_chk #(
    .N_M(N_M), .N_S(N_S), .AW(AW), .DW(DW), .PW(PW), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/prio_xbar_tb.sv
`timescale 1ns/1ps
module prio_xbar_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]   m_req, m_write, m_last;
    logic [31:0]  ad [4];
    logic [63:0]  wd [4];
    logic [127:0] m_addr;
    logic [255:0] m_wdata, m_rdata;
    logic [3:0]   m_ready, m_err;
    logic [2:0]   s_sel, s_write, s_last, s_ready, stall;
    logic [95:0]  s_addr;
    logic [191:0] s_wdata, s_rdata;
    logic         cfg_we;
    logic [1:0]   cfg_slave;
    logic [7:0]   cfg_prio;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            m_addr[i*32 +: 32]  = ad[i];
            m_wdata[i*64 +: 64] = wd[i];
        end
        for (int s = 0; s < 3; s++) begin
            s_rdata[s*64 +: 64] = {8'(s + 1), 24'h0, s_addr[s*32 +: 32]};
            s_ready[s]          = ~stall[s];
        end
    end

    prio_xbar u_dut (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_write(m_write),
        .m_last(m_last), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err),
        .s_sel(s_sel), .s_write(s_write), .s_last(s_last),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .s_ready(s_ready), .cfg_we(cfg_we), .cfg_slave(cfg_slave),
        .cfg_prio(cfg_prio)
    );

    function automatic logic [63:0] exp_rd(int s, logic [31:0] a);
        return {8'(s + 1), 24'h0, a};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(int m, logic [31:0] a, logic last, logic wr = 1'b0,
                       logic [63:0] w = 64'h0);
        m_req[m] = 1'b1; ad[m] = a; m_last[m] = last; m_write[m] = wr; wd[m] = w;
    endtask

    task automatic drop_all();
        m_req = '0; m_last = '0; m_write = '0;
    endtask

    task automatic set_prio(int s, logic [7:0] v);
        cfg_we = 1'b1; cfg_slave = 2'(s); cfg_prio = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R10 ready in reset", 64'(m_ready), 64'h0);
        chk("R10 sel in reset", 64'(s_sel), 64'h0);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R10 ready idle", 64'(m_ready), 64'h0);
        chk("R10 err idle", 64'(m_err), 64'h0);
        chk("R10 sel idle", 64'(s_sel), 64'h0);
        @(negedge clk);
    endtask

    task automatic t_decode();
        put(1, 32'h8000_0040, 1'b1, 1'b1, 64'hDEAD_BEEF_0123_4567); #1;
        chk("R1 sel slave2", 64'(s_sel), 64'h4);
        chk("R1 addr fwd", 64'(s_addr[64 +: 32]), 64'h8000_0040);
        chk("R1 wdata fwd", s_wdata[128 +: 64], 64'hDEAD_BEEF_0123_4567);
        chk("R1 write fwd", 64'(s_write), 64'h4);
        chk("R1 last fwd", 64'(s_last), 64'h4);
        chk("R9 ready m1", 64'(m_ready), 64'h2);
        chk("R9 rdata m1", m_rdata[64 +: 64], exp_rd(2, 32'h8000_0040));
        @(negedge clk); drop_all(); @(negedge clk);
    endtask

    task automatic t_concurrent();
        put(0, 32'h0000_0100, 1'b1);
        put(1, 32'h4000_0200, 1'b1);
        put(3, 32'h8000_0300, 1'b1); #1;
        chk("R3 all served", 64'(m_ready), 64'hB);
        chk("R3 all slaves", 64'(s_sel), 64'h7);
        chk("R3 rdata m0", m_rdata[0 +: 64], exp_rd(0, 32'h0000_0100));
        chk("R3 rdata m1", m_rdata[64 +: 64], exp_rd(1, 32'h4000_0200));
        chk("R3 rdata m3", m_rdata[192 +: 64], exp_rd(2, 32'h8000_0300));
        @(negedge clk); drop_all(); @(negedge clk);
    endtask

    task automatic t_unmapped();
        put(2, 32'hC000_0008, 1'b1); #1;
        chk("R2 ready", 64'(m_ready), 64'h4);
        chk("R2 err", 64'(m_err), 64'h4);
        chk("R2 no slave", 64'(s_sel), 64'h0);
        chk("R2 rdata zero", m_rdata[128 +: 64], 64'h0);
        @(negedge clk); drop_all(); @(negedge clk);
    endtask

    task automatic t_tie();
        for (int m = 0; m < 4; m++) put(m, 32'h0000_0010 + 32'(m * 8), 1'b1);
        #1;
        chk("R5 tie lowest index", 64'(m_ready), 64'h1);
        chk("R9 loser rdata zero", m_rdata[64 +: 64], 64'h0);
        chk("R5 err none", 64'(m_err), 64'h0);
        @(negedge clk); m_req[0] = 1'b0; #1;
        chk("R5 next tie winner", 64'(m_ready), 64'h2);
        chk("R5 slave addr m1", 64'(s_addr[0 +: 32]), 64'h0000_0018);
        @(negedge clk); drop_all(); @(negedge clk);
    endtask

    task automatic t_prio();
        set_prio(0, 8'h15);
        for (int m = 0; m < 4; m++) put(m, 32'h0000_0020 + 32'(m * 8), 1'b1);
        #1;
        chk("R4 best value wins", 64'(m_ready), 64'h8);
        chk("R4 slave addr m3", 64'(s_addr[0 +: 32]), 64'h0000_0038);
        @(negedge clk); m_req[3] = 1'b0; #1;
        chk("R4 equal rest lowest", 64'(m_ready), 64'h1);
        @(negedge clk); drop_all();
        set_prio(0, 8'h00);
    endtask

    task automatic t_hold();
        put(2, 32'h4000_0000, 1'b0); #1;
        chk("R6 owner first beat", 64'(m_ready), 64'h4);
        @(negedge clk);
        put(0, 32'h4000_0100, 1'b1); #1;
        chk("R6 owner kept", 64'(m_ready), 64'h4);
        chk("R6 slave addr owner", 64'(s_addr[32 +: 32]), 64'h4000_0000);
        @(negedge clk);
        m_last[2] = 1'b1; #1;
        chk("R7 release cycle", 64'(m_ready), 64'h4);
        @(negedge clk);
        m_req[2] = 1'b0; #1;
        chk("R7 rearbitrated", 64'(m_ready), 64'h1);
        chk("R7 rdata new owner", m_rdata[0 +: 64], exp_rd(1, 32'h4000_0100));
        @(negedge clk); drop_all(); @(negedge clk);
    endtask

    task automatic t_cfg_busy();
        put(1, 32'h8000_0000, 1'b0); #1;
        chk("R8 owner start", 64'(m_ready), 64'h2);
        set_prio(2, 8'h3F);
        put(3, 32'h8000_0080, 1'b1); #1;
        chk("R8 no preempt", 64'(m_ready), 64'h2);
        @(negedge clk);
        m_last[1] = 1'b1; #1;
        chk("R8 owner finishes", 64'(m_ready), 64'h2);
        @(negedge clk); #1;
        chk("R8 new prio applied", 64'(m_ready), 64'h8);
        @(negedge clk); drop_all();
        set_prio(2, 8'h00);
    endtask

    task automatic t_stall();
        stall[0] = 1'b1;
        put(3, 32'h0000_0400, 1'b1); #1;
        chk("R11 stalled ready", 64'(m_ready), 64'h0);
        chk("R11 sel while stalled", 64'(s_sel), 64'h1);
        @(negedge clk);
        put(0, 32'h0000_0500, 1'b1); #1;
        chk("R11 owner kept in stall", 64'(s_addr[0 +: 32]), 64'h0000_0400);
        @(negedge clk);
        stall[0] = 1'b0; #1;
        chk("R11 owner completes", 64'(m_ready), 64'h8);
        @(negedge clk); m_req[3] = 1'b0; #1;
        chk("R11 waiter served", 64'(m_ready), 64'h1);
        @(negedge clk); drop_all(); @(negedge clk);
    endtask

    initial begin
        drop_all(); stall = '0; cfg_we = 1'b0; cfg_slave = '0; cfg_prio = '0;
        for (int i = 0; i < 4; i++) begin ad[i] = '0; wd[i] = '0; end
        repeat (3) @(negedge clk);
        t_reset();
        t_decode();
        t_concurrent();
        t_unmapped();
        t_tie();
        t_prio();
        t_hold();
        t_cfg_busy();
        t_stall();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule